// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline Hazard Controller

This block is the control logic for a four-stage in-order pipeline. The stages are Fetch, Decode, Operate and Write, and three pipeline registers separate them. The datapath around the block holds the program counter, the instruction words and the operands. Each cycle the controller tells that datapath four things: whether the program counter advances, holds or loads a branch target; whether the Fetch/Decode register loads, holds or loads a bubble; whether Operate receives the Decode instruction or a bubble; and whether the instruction in Write commits its result. The controller keeps its own valid bit and a small copy of the decoded fields for each pipeline register. A bubble is an invalid slot. It never writes and never redirects.

There is no forwarding. An instruction that reads a register being produced by the instruction in Operate or in Write waits in Decode until the producer has left Write. Unconditional jumps are resolved in Decode and cost one slot. Conditional branches hold Fetch until Operate has decided the outcome, so they cost two slots whether taken or not.

The fetch control is a two-state machine. In `ST_STREAM`, fetch runs normally: it stalls on hazards, squashes after a jump, and holds after a conditional branch leaves Decode. The transition `ST_STREAM -> ST_RESOLVE` fires when a conditional branch leaves Decode without a stall. In `ST_RESOLVE`, the branch sits in Operate, Fetch stays idle and the taken result picks the redirect. The transition `ST_RESOLVE -> ST_STREAM` is unconditional and takes one cycle. Reset enters `ST_STREAM` with every pipeline register empty.

Top module: `pipe4_hazard_ctrl`

## Requirements
- R1: While reset is asserted, all three pipeline registers are invalid and the outputs are as follows: `pc_advance`=1, `fd_load`=1, `fd_bubble`=0, `do_bubble`=0, `pc_redirect`=0, `redirect_late`=0, `w_valid`=0 and `wb_en`=0. After reset the first instruction fetched is the one at address zero.
- R2: With no hazard, the pipeline behaves as follows. Instructions retire in program order, and each leaves Decode one cycle after its predecessor. An instruction leaving Decode in cycle e is in Write (`w_valid`=1) in cycle e+2.
- R3: A Decode instruction stalls if either of its source fields equals the destination of a valid, register-writing instruction in Operate or in Write. During the stall, `fd_load`=0, `pc_advance`=0 and `do_bubble`=1. As a result, a consumer leaves Decode no earlier than three cycles after its producer did.
- R4: A source matching the destination of a bubble, or of an instruction with its write flag clear, causes no stall.
- R5: An unconditional jump (`dec_jump`=1, which takes priority over `dec_cbr`) leaving Decode does three things in that cycle. It asserts `pc_redirect` with `redirect_late`=0, it loads a bubble into Fetch/Decode, and it does not advance the program counter. The target therefore reaches Decode two cycles after the jump did.
- R6: A conditional branch (`dec_cbr`=1) leaving Decode loads a bubble and holds the program counter. In the next cycle the branch is in Operate. The block then loads another bubble and holds the counter again. It asserts `pc_redirect` and `redirect_late` if and only if `opr_taken`=1. The following instruction (target or fall-through) reaches Decode three cycles after the branch did.
- R7: `opr_taken` is ignored unless Operate holds a valid conditional branch.
- R8: `wb_en` is 1 exactly when Write holds a valid instruction whose write flag was set. Bubbles and invalid Decode contents never assert `wb_en` or `pc_redirect`.
- R9: A stall takes priority over a branch in Decode. No redirect or bubble insertion into Fetch/Decode happens while Decode is stalled, and the branch acts in the cycle it finally leaves Decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_src | input | N_SRC*REG_W | Source register fields of the Decode instruction, source i in bits [i*REG_W +: REG_W] |
| dec_dst | input | REG_W | Destination register field of the Decode instruction |
| dec_wr | input | 1 | Decode instruction writes its destination |
| dec_jump | input | 1 | Decode instruction is an unconditional jump |
| dec_cbr | input | 1 | Decode instruction is a conditional branch |
| opr_taken | input | 1 | Taken result of the conditional branch in Operate |
| pc_advance | output | 1 | Increment the program counter this cycle |
| pc_redirect | output | 1 | Load the branch target into the program counter this cycle |
| redirect_late | output | 1 | Redirect target comes from Operate (1) or Decode (0) |
| fd_load | output | 1 | Fetch/Decode register loads this cycle (0 = hold) |
| fd_bubble | output | 1 | When loading, Fetch/Decode receives a bubble |
| do_bubble | output | 1 | Decode/Operate receives a bubble instead of the Decode instruction |
| w_valid | output | 1 | Write stage holds a valid instruction |
| wb_en | output | 1 | Commit the Write-stage result to the register file |

## Verification
The bench builds short programs over a handful of registers and walks each one. From the program alone it derives the order in which instructions should retire and the cycle of each retirement. The runs go after dependencies at distances one, two and three, writers whose write flag is clear, jumps and conditional branches in both outcomes, and branches that themselves wait on a dependency. Skipping the Write-stage comparison would retire a consumer one cycle early. Resolving a conditional branch in Decode would retire its successor early, or retire the aborted fall-through. Honouring `opr_taken` outside a branch would jump to a stray target. A branch acting while stalled would lose the instruction held in Decode.

// File: rtl/p4h_pkg.sv
package p4h_pkg;

    typedef enum logic [0:0] {
        ST_STREAM  = 1'b0,
        ST_RESOLVE = 1'b1
    } fetch_st_e;

    typedef struct packed {
        logic vld;
        logic wr;
        logic cbr;
    } stage_flags_t;

endpackage

// File: rtl/p4h_stage_track.sv
module p4h_stage_track
    import p4h_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fd_load,
    input  logic             fd_bubble,
    input  logic             do_bubble,
    input  logic [REG_W-1:0] dec_dst,
    input  logic             dec_wr,
    input  logic             dec_cbr,
    output logic             d_vld,
    output stage_flags_t     o_flags,
    output logic [REG_W-1:0] o_dst,
    output logic             w_vld,
    output logic             w_wr,
    output logic [REG_W-1:0] w_dst
);

    logic fd_fill;

    assign fd_fill = fd_load && !fd_bubble;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_vld <= 1'b0;
        end else if (fd_load) begin
            d_vld <= fd_fill;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_flags <= '0;
            o_dst   <= '0;
        end else begin
            o_flags.vld <= d_vld && !do_bubble;
            o_flags.wr  <= dec_wr;
            o_flags.cbr <= dec_cbr;
            o_dst       <= dec_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_vld <= 1'b0;
            w_wr  <= 1'b0;
            w_dst <= '0;
        end else begin
            w_vld <= o_flags.vld;
            w_wr  <= o_flags.wr;
            w_dst <= o_dst;
        end
    end

    AST_STALL_GIVES_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        do_bubble |=> !o_flags.vld); // R3

    AST_FROZEN_DECODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (d_vld && !fd_load) |=> d_vld); // R9

endmodule

// File: rtl/p4h_dep_check.sv
module p4h_dep_check #(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic                   d_vld,
    input  logic [N_SRC*REG_W-1:0] srcs,
    input  logic                   o_vld,
    input  logic                   o_wr,
    input  logic [REG_W-1:0]       o_dst,
    input  logic                   w_vld,
    input  logic                   w_wr,
    input  logic [REG_W-1:0]       w_dst,
    output logic                   hazard
);

    logic             o_live;
    logic             w_live;
    logic [N_SRC-1:0] hit;

    assign o_live = o_vld && o_wr;
    assign w_live = w_vld && w_wr;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic [REG_W-1:0] s_id;
        assign s_id   = srcs[i*REG_W +: REG_W];
        assign hit[i] = (o_live && (s_id == o_dst)) || (w_live && (s_id == w_dst));
    end

    assign hazard = d_vld && (|hit);

endmodule

// File: rtl/p4h_fetch_fsm.sv
module p4h_fetch_fsm
    import p4h_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic d_vld,
    input  logic dec_jump,
    input  logic dec_cbr,
    input  logic hazard,
    input  logic o_cbr_vld,
    input  logic opr_taken,
    output logic pc_advance,
    output logic pc_redirect,
    output logic redirect_late,
    output logic fd_load,
    output logic fd_bubble,
    output logic do_bubble
);

    fetch_st_e st_q;
    fetch_st_e st_d;
    logic      go;
    logic      go_jump;
    logic      go_cbr;

    assign go      = d_vld && !hazard;
    assign go_jump = go && dec_jump;
    assign go_cbr  = go && dec_cbr && !dec_jump;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_STREAM;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STREAM:  st_d = go_cbr ? ST_RESOLVE : ST_STREAM;
            ST_RESOLVE: st_d = ST_STREAM;
            default:    st_d = ST_STREAM;
        endcase
    end

    always_comb begin
        pc_advance    = 1'b0;
        pc_redirect   = 1'b0;
        redirect_late = 1'b0;
        fd_load       = 1'b1;
        fd_bubble     = 1'b0;
        do_bubble     = 1'b0;
        unique case (st_q)
            ST_STREAM: begin
                do_bubble   = hazard;
                fd_load     = !hazard;
                fd_bubble   = go_jump || go_cbr;
                pc_redirect = go_jump;
                pc_advance  = !hazard && !go_jump && !go_cbr;
            end
            ST_RESOLVE: begin
                fd_bubble     = 1'b1;
                pc_redirect   = o_cbr_vld && opr_taken;
                redirect_late = o_cbr_vld && opr_taken;
            end
            default: begin
                fd_load = 1'b1;
            end
        endcase
    end

    AST_RESOLVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESOLVE) |=> (st_q == ST_STREAM)); // R6

    AST_RESOLVE_SEES_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESOLVE) |-> o_cbr_vld); // R6

    AST_HOLD_AFTER_CBR: assert property (@(posedge clk) disable iff (!rst_n)
        go_cbr |=> (!pc_advance && fd_bubble)); // R6

endmodule

// File: rtl/pipe4_hazard_ctrl.sv
module pipe4_hazard_ctrl
    import p4h_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC*REG_W-1:0] dec_src,
    input  logic [REG_W-1:0]       dec_dst,
    input  logic                   dec_wr,
    input  logic                   dec_jump,
    input  logic                   dec_cbr,
    input  logic                   opr_taken,
    output logic                   pc_advance,
    output logic                   pc_redirect,
    output logic                   redirect_late,
    output logic                   fd_load,
    output logic                   fd_bubble,
    output logic                   do_bubble,
    output logic                   w_valid,
    output logic                   wb_en
);

    logic             d_vld;
    stage_flags_t     o_flags;
    logic [REG_W-1:0] o_dst;
    logic             w_vld;
    logic             w_wr;
    logic [REG_W-1:0] w_dst;
    logic             hazard;
    logic             o_cbr_vld;

    assign o_cbr_vld = o_flags.vld && o_flags.cbr;

    p4h_stage_track #(.REG_W(REG_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .fd_load   (fd_load),
        .fd_bubble (fd_bubble),
        .do_bubble (do_bubble),
        .dec_dst   (dec_dst),
        .dec_wr    (dec_wr),
        .dec_cbr   (dec_cbr),
        .d_vld     (d_vld),
        .o_flags   (o_flags),
        .o_dst     (o_dst),
        .w_vld     (w_vld),
        .w_wr      (w_wr),
        .w_dst     (w_dst)
    );

    p4h_dep_check #(.REG_W(REG_W), .N_SRC(N_SRC)) u_dep (
        .d_vld  (d_vld),
        .srcs   (dec_src),
        .o_vld  (o_flags.vld),
        .o_wr   (o_flags.wr),
        .o_dst  (o_dst),
        .w_vld  (w_vld),
        .w_wr   (w_wr),
        .w_dst  (w_dst),
        .hazard (hazard)
    );

    p4h_fetch_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .d_vld         (d_vld),
        .dec_jump      (dec_jump),
        .dec_cbr       (dec_cbr),
        .hazard        (hazard),
        .o_cbr_vld     (o_cbr_vld),
        .opr_taken     (opr_taken),
        .pc_advance    (pc_advance),
        .pc_redirect   (pc_redirect),
        .redirect_late (redirect_late),
        .fd_load       (fd_load),
        .fd_bubble     (fd_bubble),
        .do_bubble     (do_bubble)
    );

    assign w_valid = w_vld;
    assign wb_en   = w_vld && w_wr;

    AST_BUBBLE_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        !o_flags.vld |=> !wb_en); // R8

    AST_JUMP_SQUASHES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_redirect && !redirect_late) |=> !d_vld); // R5

    AST_LATE_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_late |-> (o_cbr_vld && opr_taken)); // R7

    AST_STALL_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        do_bubble |-> !pc_redirect); // R9

endmodule

// File: tb/pipe4_hazard_ctrl_tb_top.sv
module pipe4_hazard_ctrl_tb_top;

    localparam int REG_W = 3;
    localparam int N_SRC = 2;
    localparam int MEM   = 64;
    localparam int K     = 40;
    localparam int SEEDS = 40;
    localparam int LIMIT = 2000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;

    logic [1:0]       p_kind [MEM];
    logic [REG_W-1:0] p_sa   [MEM];
    logic [REG_W-1:0] p_sb   [MEM];
    logic [REG_W-1:0] p_dst  [MEM];
    logic             p_wr   [MEM];
    logic [5:0]       p_tgt  [MEM];
    logic             p_tk   [MEM];

    int    tr_a [K];
    int    ee   [K];
    string t_tag[K];
    string i_tag[K];

    logic [5:0] pc, fd_a, do_a, ow_a;
    logic       fd_v, do_v, ow_v;
    logic       noise;
    int         cyc;
    int         sd;
    int         rk;
    bit         run;
    int         n_chk;
    int         n_err;

    logic [N_SRC*REG_W-1:0] dec_src;
    logic [REG_W-1:0]       dec_dst;
    logic dec_wr, dec_jump, dec_cbr, opr_taken;
    logic pc_advance, pc_redirect, redirect_late, fd_load, fd_bubble, do_bubble, w_valid, wb_en;

    pipe4_hazard_ctrl #(.REG_W(REG_W), .N_SRC(N_SRC)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec_src       (dec_src),
        .dec_dst       (dec_dst),
        .dec_wr        (dec_wr),
        .dec_jump      (dec_jump),
        .dec_cbr       (dec_cbr),
        .opr_taken     (opr_taken),
        .pc_advance    (pc_advance),
        .pc_redirect   (pc_redirect),
        .redirect_late (redirect_late),
        .fd_load       (fd_load),
        .fd_bubble     (fd_bubble),
        .do_bubble     (do_bubble),
        .w_valid       (w_valid),
        .wb_en         (wb_en)
    );

    // decode fields follow the Fetch/Decode slot; invalid slots carry noise
    always_comb begin
        dec_src   = {p_sb[fd_a], p_sa[fd_a]};
        dec_dst   = p_dst[fd_a];
        dec_wr    = fd_v ? p_wr[fd_a] : noise;
        dec_jump  = fd_v ? (p_kind[fd_a] == 2'd1) : noise;
        dec_cbr   = fd_v ? (p_kind[fd_a] == 2'd2) : !noise;
        opr_taken = (do_v && p_kind[do_a] == 2'd2) ? p_tk[do_a] : noise;
    end

    // minimal datapath model steered by the controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; fd_v <= 1'b0; do_v <= 1'b0; ow_v <= 1'b0;
            fd_a <= '0; do_a <= '0; ow_a <= '0; cyc <= 0; noise <= 1'b0;
        end else begin
            cyc   <= cyc + 1;
            noise <= cyc[0] ^ cyc[3] ^ sd[0];
            if (pc_redirect) pc <= redirect_late ? p_tgt[do_a] : p_tgt[fd_a];
            else if (pc_advance) pc <= pc + 6'd1;
            if (fd_load) begin
                fd_v <= !fd_bubble;
                fd_a <= pc;
            end
            do_v <= do_bubble ? 1'b0 : fd_v;
            do_a <= fd_a;
            ow_v <= do_v;
            ow_a <= do_a;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mix(input int a, input int s);
        logic [31:0] x;
        x = (32'(a) * 32'h9E3779B1) ^ (32'(s + 1) * 32'h85EBCA77);
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 12);
        return x;
    endfunction

    task automatic build_program(input int s);
        for (int a = 0; a < MEM; a++) begin
            logic [31:0] h;
            logic [3:0]  r;
            int mode;
            h = mix(a, s);
            r = h[3:0];
            mode = s % 4;
            p_kind[a] = 2'd0;
            if (mode == 1 && r < 4'd2) p_kind[a] = 2'd1;
            if (mode == 2 && r < 4'd3) p_kind[a] = 2'd2;
            if (mode == 3 && r == 4'd0) p_kind[a] = 2'd1;
            if (mode == 3 && (r == 4'd1 || r == 4'd2)) p_kind[a] = 2'd2;
            p_sa[a]  = {1'b0, h[5:4]};
            p_sb[a]  = {1'b0, h[7:6]};
            p_dst[a] = {h[10] & h[11], h[9:8]};
            p_wr[a]  = (p_kind[a] == 2'd0) && (h[13:12] != 2'd0);
            p_tgt[a] = 6'(a + 2 + int'(h[16:14]));
            p_tk[a]  = h[17];
        end
    endtask

    // architectural order and timing derived from the requirements
    task automatic build_expect();
        int a;
        a = 0;
        for (int k = 0; k < K; k++) begin
            tr_a[k] = a;
            if (p_kind[a] == 2'd1 || (p_kind[a] == 2'd2 && p_tk[a])) a = int'(p_tgt[a]);
            else a = (a + 1) % MEM;
        end
        for (int k = 0; k < K; k++) begin
            int lo;
            int pa;
            int ca;
            ca = tr_a[k];
            if (k == 0) begin
                lo = 1; t_tag[k] = "R1"; i_tag[k] = "R1";
            end else begin
                pa = tr_a[k-1];
                lo = ee[k-1] + 1;
                t_tag[k] = "R2,R4"; i_tag[k] = "R2";
                if (p_kind[pa] == 2'd1) begin lo = ee[k-1] + 2; t_tag[k] = "R5"; i_tag[k] = "R5"; end
                if (p_kind[pa] == 2'd2) begin lo = ee[k-1] + 3; t_tag[k] = "R6"; i_tag[k] = "R6,R7"; end
            end
            for (int j = 0; j < k; j++) begin
                int ja;
                ja = tr_a[j];
                if (p_wr[ja] && (p_dst[ja] == p_sa[ca] || p_dst[ja] == p_sb[ca]) && ee[j] + 3 > lo) begin
                    lo = ee[j] + 3;
                    t_tag[k] = (p_kind[ca] != 2'd0) ? "R3,R9" : "R3";
                end
            end
            ee[k] = lo;
        end
    endtask

    always @(negedge clk) begin
        if (run && rst_n && rk < K) begin
            // R9: stall freezes Fetch/Decode and blocks redirects
            if (do_bubble)
                chk(!fd_load && !pc_advance && !pc_redirect, "R9", "stall with fetch motion",
                    int'({fd_load, pc_advance, pc_redirect}), 0);
            // R6: a taken branch in Operate redirects late
            if (do_v && p_kind[do_a] == 2'd2)
                chk(pc_redirect == p_tk[do_a] && redirect_late == p_tk[do_a], "R6",
                    "late redirect", int'(pc_redirect), int'(p_tk[do_a]));
            // R7: taken noise outside a branch must not redirect late
            if (!(do_v && p_kind[do_a] == 2'd2) && opr_taken)
                chk(!redirect_late, "R7", "stray taken honoured", int'(redirect_late), 0);
            // R8: write enable
            chk(wb_en == (w_valid && p_wr[ow_a]), "R8", "wb_en", int'(wb_en), int'(w_valid && p_wr[ow_a]));
            chk(w_valid == ow_v, "R2", "write-stage valid vs model", int'(w_valid), int'(ow_v));
            if (w_valid) begin
                chk(int'(ow_a) == tr_a[rk], i_tag[rk], "retired address", int'(ow_a), tr_a[rk]);
                chk(cyc == ee[rk] + 2, t_tag[rk], "retire cycle", cyc, ee[rk] + 2);
                rk++;
            end
        end
    end

    initial begin
        n_chk = 0; n_err = 0; run = 1'b0; rk = 0; sd = 0;
        rst_n = 1'b0;
        for (int s = 0; s < SEEDS; s++) begin
            int waited;
            sd = s;
            build_program(s);
            build_expect();
            run = 1'b0;
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            chk(pc_advance && fd_load && !fd_bubble && !do_bubble && !pc_redirect && !redirect_late
                && !w_valid && !wb_en, "R1", "reset outputs",
                int'({pc_advance, fd_load, fd_bubble, do_bubble, pc_redirect, redirect_late, w_valid, wb_en}),
                8'b1100_0000);
            rk = 0;
            run = 1'b1;
            rst_n = 1'b1;
            waited = 0;
            while (rk < K && waited < LIMIT) begin
                @(negedge clk);
                waited++;
            end
            chk(rk == K, "R2", "retired count before watchdog", rk, K);
            run = 1'b0;
        end
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule